// File: doc/BRIEF.md
# Binary Early/Late Phase Detector Decision Logic

This block is the digital decision stage of a three-sample bang-bang phase detector for a clock and data recovery loop. Once per recovered-clock cycle it receives a pair of samples: one taken at the centre of the data eye and one taken half a bit earlier, on the boundary between the previous bit and the current one. It keeps the previous centre sample. It compares that previous bit, the boundary sample and the current centre sample, and decides whether the recovered clock is early or late, or whether there is nothing to judge. Zero phase error means the data transition lines up with the falling clock edge, so that the rising edge sits in the middle of the eye.

The decision is a one-cycle pulse. `pump_dn` is a request to lower the oscillator control when the clock is early. `pump_up` is a request to raise it when the clock is late. Both pulses go to a loop filter or phase accumulator downstream. Because every pulse lasts exactly one clock, a long run of identical bits leaves the loop still and does not push it steadily one way. Alongside the pulses, the block presents the retimed data bit as an output beat. A saturating net counter of up pulses minus down pulses can be included for observation.

The sample stream in is qualified by `smp_valid`, and the beat stream out by `ret_valid`. A recovered-clock sampler cannot be stalled, so neither side has a ready signal. Every accepted sample produces exactly one output beat on the following cycle, and the consumer must take every beat. Cycles in which `smp_valid` is low are gaps: they produce no beat and no pulse, and they leave the stored previous bit unchanged.

Top module: `bbpd_core`

## Requirements
- R1: With synchronous active-high `rst` sampled high, the next cycle shows `ret_valid`, `pump_up` and `pump_dn` low, `net_count` zero, and no stored previous bit.
- R2: A sample accepted with `smp_valid` high produces `ret_valid` high on the next cycle, with `ret_bit` equal to that sample's `smp_centre`.
- R3: When an accepted centre sample differs from the stored previous bit and `smp_edge` equals the new centre sample (clock late), `pump_up` is high in the output cycle of that sample.
- R4: When an accepted centre sample differs from the stored previous bit and `smp_edge` equals the previous bit (clock early), `pump_dn` is high in the output cycle of that sample.
- R5: When an accepted centre sample equals the stored previous bit, neither `pump_up` nor `pump_dn` is asserted, whatever `smp_edge` is.
- R6: `pump_up` and `pump_dn` are never high in the same cycle.
- R7: Each pulse lasts one cycle for each deciding sample. A cycle with `smp_valid` low gives `ret_valid`, `pump_up` and `pump_dn` low on the next cycle and keeps the stored previous bit.
- R8: The first accepted sample after reset has no previous bit to compare with, so it produces a beat but no pulse.
- R9: `net_count` is a two's complement value of CNT_W bits. It rises by one with each `pump_up` and falls by one with each `pump_dn`, in the same cycle as the pulse, and it holds at 2^(CNT_W-1)-1 and at -2^(CNT_W-1).
- R10: There is no back-pressure. The number of output beats equals the number of accepted samples, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample pair present this cycle |
| smp_centre | input | 1 | Eye-centre data sample |
| smp_edge | input | 1 | Boundary sample taken half a bit before the centre sample |
| ret_valid | output | 1 | Retimed bit beat present |
| ret_bit | output | 1 | Retimed data bit |
| pump_up | output | 1 | One-cycle request to raise the oscillator control (clock late) |
| pump_dn | output | 1 | One-cycle request to lower the oscillator control (clock early) |
| net_count | output | CNT_W | Saturating net up-minus-down count |

## Verification
The hardest condition to reach from the ports is the saturation of `net_count` at each limit, since the counter only moves on transitions that are judged consistently one way. The stimulus drives long alternating bit patterns with the boundary sample matching the new bit, which pushes the count past its maximum. It then drives the same patterns with the boundary sample matching the old bit, which drives the count down through zero and past its minimum. Gaps inserted between a differing pair of samples check that a transition is still judged across an idle cycle, and random phases mix the three decisions.

// File: rtl/bbpd_pkg.sv
package bbpd_pkg;
  typedef enum logic [1:0] {
    DEC_HOLD  = 2'b00,
    DEC_LATE  = 2'b01,
    DEC_EARLY = 2'b10
  } pd_dec_e;
endpackage

// File: rtl/bbpd_decide.sv
module bbpd_decide
  import bbpd_pkg::*;
(
  input  logic    have_prev,
  input  logic    prev_bit,
  input  logic    centre,
  input  logic    edge_s,
  output pd_dec_e decision
);
  logic moved;
  assign moved = have_prev && (prev_bit != centre);

  always_comb begin
    decision = DEC_HOLD;
    if (moved) begin
      if (edge_s == centre) decision = DEC_LATE;
      else                  decision = DEC_EARLY;
    end
  end
endmodule

// File: rtl/bbpd_tally.sv
module bbpd_tally #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] BOT = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)                      count <= '0;
    else if (inc && count != TOP) count <= count + ONE;
    else if (dec && count != BOT) count <= count - ONE;
  end
endmodule

// File: rtl/bbpd_core.sv
module bbpd_core
  import bbpd_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter bit HAS_TALLY = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic             smp_centre,
  input  logic             smp_edge,
  output logic             ret_valid,
  output logic             ret_bit,
  output logic             pump_up,
  output logic             pump_dn,
  output logic [CNT_W-1:0] net_count
);
  logic    prev_q;
  logic    have_q;
  pd_dec_e dec_w;
  logic    late_w;
  logic    early_w;

  bbpd_decide u_decide (
    .have_prev (have_q),
    .prev_bit  (prev_q),
    .centre    (smp_centre),
    .edge_s    (smp_edge),
    .decision  (dec_w)
  );

  assign late_w  = smp_valid && (dec_w == DEC_LATE);
  assign early_w = smp_valid && (dec_w == DEC_EARLY);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= 1'b0;
      have_q    <= 1'b0;
      ret_valid <= 1'b0;
      ret_bit   <= 1'b0;
      pump_up   <= 1'b0;
      pump_dn   <= 1'b0;
    end else begin
      ret_valid <= smp_valid;
      pump_up   <= late_w;
      pump_dn   <= early_w;
      if (smp_valid) begin
        ret_bit <= smp_centre;
        prev_q  <= smp_centre;
        have_q  <= 1'b1;
      end
    end
  end

  generate
    if (HAS_TALLY) begin : g_tally
      bbpd_tally #(.CNT_W(CNT_W)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .inc   (late_w),
        .dec   (early_w),
        .count (net_count)
      );
    end else begin : g_no_tally
      assign net_count = '0;
    end
  endgenerate
endmodule

// File: rtl/bbpd_chk.sv
module bbpd_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_valid,
  input logic             smp_centre,
  input logic             smp_edge,
  input logic             ret_valid,
  input logic             ret_bit,
  input logic             pump_up,
  input logic             pump_dn,
  input logic [CNT_W-1:0] net_count
);
  localparam logic [CNT_W-1:0] TOP = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] BOT = {1'b1, {(CNT_W-1){1'b0}}};

  logic seen_q, last_q, armed_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q  <= 1'b0;
      last_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (smp_valid) begin
        seen_q <= 1'b1;
        last_q <= smp_centre;
      end
    end
  end

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(pump_up && pump_dn));
  assert_beat_R2: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> ret_valid && ret_bit == $past(smp_centre));
  assert_gap_R7: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !ret_valid && !pump_up && !pump_dn);
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    smp_valid && seen_q && smp_centre == last_q |=> !pump_up && !pump_dn);
  assert_late_R3: assert property (@(posedge clk) disable iff (rst)
    smp_valid && seen_q && smp_centre != last_q && smp_edge == smp_centre |=> pump_up);
  assert_early_R4: assert property (@(posedge clk) disable iff (rst)
    smp_valid && seen_q && smp_centre != last_q && smp_edge == last_q |=> pump_dn);
  assert_first_R8: assert property (@(posedge clk) disable iff (rst)
    smp_valid && !seen_q |=> !pump_up && !pump_dn);
  assert_count_up_R9: assert property (@(posedge clk) disable iff (rst)
    armed_q && pump_up && $past(net_count) != TOP |-> net_count == $past(net_count) + 1'b1);
  assert_count_dn_R9: assert property (@(posedge clk) disable iff (rst)
    armed_q && pump_dn && $past(net_count) != BOT |-> net_count == $past(net_count) - 1'b1);
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
    armed_q && !pump_up && !pump_dn |-> $stable(net_count));
endmodule

bind bbpd_core bbpd_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_bbpd_core.sv
module test_bbpd_core;
  localparam int W = 6;
  localparam int CMAX = (1 << (W-1)) - 1;
  localparam int CMIN = -(1 << (W-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0, smp_centre = 1'b0, smp_edge = 1'b0;
  logic ret_valid, ret_bit, pump_up, pump_dn;
  logic [W-1:0] net_count;

  always #5 clk = ~clk;

  bbpd_core #(.CNT_W(W), .HAS_TALLY(1'b1)) i_bbpd_core (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_centre(smp_centre),
    .smp_edge(smp_edge), .ret_valid(ret_valid), .ret_bit(ret_bit),
    .pump_up(pump_up), .pump_dn(pump_dn), .net_count(net_count));

  int applied = 0, miscompares = 0;
  int m_have = 0, m_prev = 0, m_cnt = 0;
  int e_rv = 0, e_rb = 0, e_up = 0, e_dn = 0;
  int beats_in = 0, beats_out = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    applied++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input bit c, input bit e);
    string tag;
    smp_valid = v; smp_centre = c; smp_edge = e;
    e_rv = v; e_up = 0; e_dn = 0;
    if (v) begin
      beats_in++;
      e_rb = c;
      if (m_have != 0 && m_prev != int'(c)) begin
        if (int'(e) == int'(c)) begin e_up = 1; if (m_cnt < CMAX) m_cnt++; end
        else begin e_dn = 1; if (m_cnt > CMIN) m_cnt--; end
      end
      m_have = 1; m_prev = c;
    end
    @(posedge clk);
    #2;
    if (ret_valid) beats_out++;
    if (!v) tag = "R7";
    else if (e_up != 0) tag = "R3";
    else if (e_dn != 0) tag = "R4";
    else tag = "R5/R8";
    chk({"R2 valid ", tag}, int'(ret_valid), e_rv);
    if (v) chk("R2 bit", int'(ret_bit), e_rb);
    chk({"up ", tag}, int'(pump_up), e_up);
    chk({"dn ", tag}, int'(pump_dn), e_dn);
    chk("R6 exclusive", int'(pump_up && pump_dn), 0);
    chk("R9 count", int'($signed(net_count)), m_cnt);
    #3;
  endtask

  task automatic do_reset();
    rst = 1'b1; smp_valid = 1'b0;
    @(posedge clk); #2;
    rst = 1'b0;
    m_have = 0; m_prev = 0; m_cnt = 0;
    chk("R1 ret_valid", int'(ret_valid), 0);
    chk("R1 pump_up", int'(pump_up), 0);
    chk("R1 pump_dn", int'(pump_dn), 0);
    chk("R1 net_count", int'($signed(net_count)), 0);
    #3;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R8: first sample after reset, with a "transition-like" value
    step(1, 1, 1);
    // R5: run of ones, edge noise ignored
    for (int i = 0; i < 6; i++) step(1, 1, i[0]);
    // R3 late, R4 early single cases
    step(1, 0, 0);
    step(1, 1, 0);
    // R7: gaps keep previous bit; transition across gap still judged
    step(0, 0, 0);
    step(0, 1, 1);
    step(1, 0, 0);
    // R9: saturate high with late alternations
    for (int i = 0; i < 2*CMAX + 10; i++) step(1, i[0] ? 1'b1 : 1'b0, i[0] ? 1'b1 : 1'b0);
    // R9: saturate low with early alternations
    for (int i = 0; i < 4*CMAX + 12; i++) step(1, i[0] ? 1'b0 : 1'b1, i[0] ? 1'b1 : 1'b0);
    // random mix with gaps
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 7);
      step(r != 0, r[1], r[2]);
    end
    // R1/R8: reset mid-stream clears previous bit
    step(1, 1, 1);
    do_reset();
    step(1, 0, 1);
    step(1, 1, 1);
    step(0, 0, 0);
    chk("R10 beats", beats_out, beats_in);
    done = 1'b1;
  end

  initial begin
    for (int k = 0; k < 20000 && !done; k++) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule